// File: doc/BRIEF.md
# Four-Phase Zoned Cell Pipeline

This block is a cycle-level digital model of a line of bistable cells. The cells are split into clock zones. Each zone follows its own copy of a four-step zone clock: relax, switch, hold, release. Each zone runs one step behind the zone before it. A cell carries a binary value together with a polarized flag. A cell with the flag clear is null.

Data enters from a single input bit. It is taken into the first zone at the close of that zone's relax step. It then hands forward one zone per step, and only while the upstream zone is locked. One selectable zone starts with a gate cell. The gate combines the incoming value with a side input and can act as a plain wire, as a three-input majority with its third input tied low (AND) or tied high (OR), or as an inverter.

The output bit is qualified by a valid flag. The flag is high only while the last zone is in hold and carries polarized data. Each zone step lasts a parameter number of system clock cycles.

Top module: `qpipe_chain`

## Requirements
- R1: While rst_n is low, and for the rest of the cycle in which it is released, every zone reads release (code 3), dout_valid is 0 and dout is 0.
- R2: Each zone steps through relax (0), switch (1), hold (2), release (3) in that order and then repeats. Each step lasts PHASE_CYCLES clock cycles. Zone 0 reads relax in the first cycle after the cycle in which reset is released.
- R3: Zone z+1 always reads one step behind zone z (its code is zone z's code minus 1, modulo 4). A zone enters switch exactly when its upstream zone enters hold. Zone z occupies bits [2z+1:2z] of zone_phase.
- R4: A value, once latched, stays unchanged through switch and hold. Changes on din, side_in or gate_mode after their sampling cycle have no effect on the value delivered by that wave.
- R5: A cell is null in release and relax. dout reads 0 whenever the last zone is null.
- R6: With the default 4 zones, din is sampled in the last cycle of zone 0's relax. The result is on dout in the hold step of the last zone. That hold step begins 5*PHASE_CYCLES cycles after the first cycle of that relax.
- R7: dout_valid is high only in the last zone's hold step. It is low in that zone's switch and release steps.
- R8: The gate zone (default zone 1) samples side_in and gate_mode in the last cycle of its relax. gate_mode 0 passes din, 1 gives majority(din, side_in, 0), 2 gives majority(din, side_in, 1), and 3 gives the inverse of din.
- R9: Null propagates. The first hold step of the last zone after reset, which sees no data yet, keeps dout_valid low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| din | input | 1 | Data bit into zone 0 |
| side_in | input | 1 | Second gate operand |
| gate_mode | input | 2 | Gate function: 0 wire, 1 AND, 2 OR, 3 invert |
| dout | output | 1 | Value of the last cell, 0 when null |
| dout_valid | output | 1 | High while the last zone holds polarized data |
| zone_phase | output | 2*NUM_ZONES | Current step code of every zone |

## Verification
A wave is keyed to the first cycle of zone 0's relax, which the bench finds by watching zone_phase. With a one-cycle step, dout_valid must still be low 4 cycles later. The result and valid appear at 5 cycles, and the output is back to null at 6 cycles. The gate operands are due one cycle after din is sampled, so the bench holds every operand for a whole four-cycle period.

A second instance with a three-cycle step is used for the stretched timing. It has its result due across cycles 15 to 17, and its inputs are toggled during that window to show they are ignored. The reset values and the phase codes of the first four cycles after reset are checked cycle by cycle.

// File: rtl/qpipe_pkg.sv
// Shared types and helper functions for the zoned cell pipeline.
// Assumes the zone step codes are ordered so that +1 modulo 4 is the next step.
package qpipe_pkg;

    typedef enum logic [1:0] {
        PH_RELAX   = 2'd0,
        PH_SWITCH  = 2'd1,
        PH_HOLD    = 2'd2,
        PH_RELEASE = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        GM_WIRE = 2'd0,
        GM_AND  = 2'd1,
        GM_OR   = 2'd2,
        GM_INV  = 2'd3
    } gate_mode_e;

    // Three-input majority vote.
    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (b & c) | (a & c);
    endfunction

    // Gate cell function selected by the mode code.
    function automatic logic gate_eval(input logic a, input logic b, input logic [1:0] mode);
        logic r;
        case (mode)
            GM_WIRE: r = a;
            GM_AND:  r = maj3(a, b, 1'b0);
            GM_OR:   r = maj3(a, b, 1'b1);
            default: r = ~a;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/qpipe_phase_gen.sv
// Zone clock generator: one shared step counter, with each zone offset by one step.
// Assumes reset forces every zone into release. Running starts one cycle after reset ends.
module qpipe_phase_gen
    import qpipe_pkg::*;
#(
    parameter int NUM_ZONES    = 4,
    parameter int PHASE_CYCLES = 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    output logic [2*NUM_ZONES-1:0] zone_phase,
    output logic                   step
);

    localparam int SUB_W = (PHASE_CYCLES > 1) ? $clog2(PHASE_CYCLES) : 1;
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(PHASE_CYCLES - 1);

    logic             run;
    logic [SUB_W-1:0] sub;
    logic [1:0]       base;

    // Advance the dwell counter, and the shared step when a dwell ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run  <= 1'b0;
            sub  <= '0;
            base <= 2'd0;
        end else if (!run) begin
            run <= 1'b1;
        end else if (sub == SUB_LAST) begin
            sub  <= '0;
            base <= base + 2'd1;
        end else begin
            sub <= sub + 1'b1;
        end
    end

    // Last cycle of the current step, common to all zones.
    assign step = run && (sub == SUB_LAST);

    generate
        for (genvar z = 0; z < NUM_ZONES; z++) begin : g_zone_ph
            // Each zone lags its upstream neighbour by one step.
            assign zone_phase[2*z +: 2] = run ? (base - 2'(z)) : PH_RELEASE;
        end
        for (genvar z = 1; z < NUM_ZONES; z++) begin : g_lag_chk
            // R3: a zone locks in the step where its upstream zone starts to hold
            a_r3_lock_on_hold: assert property (@(posedge clk) disable iff (!rst_n)
                (zone_phase[2*z +: 2] == PH_SWITCH && $past(zone_phase[2*z +: 2]) == PH_RELAX)
                |-> zone_phase[2*(z-1) +: 2] == PH_HOLD);
        end
    endgenerate

    // R2: zone 0 only ever moves on to the next step code
    a_r2_phase_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (zone_phase[1:0] != $past(zone_phase[1:0]))
        |-> zone_phase[1:0] == $past(zone_phase[1:0]) + 2'd1);

    // R1: all zones read release in the cycle reset is let go
    a_r1_release_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> zone_phase == {(2*NUM_ZONES){1'b1}});

endmodule

// File: rtl/qpipe_zone.sv
// One clock zone of cells. All cells settle together at the end of relax, lock in
// switch, drive downstream in hold, and drop to null at the end of hold.
// Assumes upstream is locked whenever this zone captures. The optional gate sits in cell 0.
module qpipe_zone
    import qpipe_pkg::*;
#(
    parameter int CELLS    = 2,
    parameter bit HAS_GATE = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] phase,
    input  logic       step,
    input  logic       up_val,
    input  logic       up_pol,
    input  logic       side_in,
    input  logic [1:0] gate_mode,
    output logic       tail_val,
    output logic       tail_pol
);

    logic [CELLS-1:0] val_q;
    logic [CELLS-1:0] pol_q;
    logic [CELLS-1:0] val_d;
    logic             cap;
    logic             clr;
    logic             head_in;

    // Capture at the last relax cycle, clear at the last hold cycle.
    assign cap = step && (phase == PH_RELAX);
    assign clr = step && (phase == PH_HOLD);

    // Value entering cell 0: the gate result, or the upstream bit.
    assign head_in = HAS_GATE ? gate_eval(up_val, side_in, gate_mode) : up_val;

    // Domino settle: each cell copies its neighbour within the zone.
    always_comb begin
        val_d[0] = head_in;
        for (int k = 1; k < CELLS; k++) begin
            val_d[k] = val_d[k-1];
        end
    end

    // Cell state: latch on capture, go null on clear, else keep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q <= '0;
            pol_q <= '0;
        end else if (cap) begin
            val_q <= val_d;
            pol_q <= {CELLS{up_pol}};
        end else if (clr) begin
            val_q <= '0;
            pol_q <= '0;
        end
    end

    assign tail_val = val_q[CELLS-1];
    assign tail_pol = pol_q[CELLS-1];

    // R4: nothing moves inside a zone across consecutive hold cycles
    a_r4_hold_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HOLD && $past(phase) == PH_HOLD) |-> ($stable(val_q) && $stable(pol_q)));

    // R5: cells are null in release and relax
    a_r5_null_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_RELEASE || phase == PH_RELAX) |-> pol_q == '0);

endmodule

// File: rtl/qpipe_chain.sv
// Top of the zoned cell pipeline: the zone clock generator and a line of zones.
// Zone GATE_ZONE carries the configurable gate. Output is qualified by last-zone hold.
// Assumes GATE_ZONE < NUM_ZONES.
module qpipe_chain
    import qpipe_pkg::*;
#(
    parameter int NUM_ZONES      = 4,
    parameter int CELLS_PER_ZONE = 2,
    parameter int PHASE_CYCLES   = 1,
    parameter int GATE_ZONE      = 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   din,
    input  logic                   side_in,
    input  logic [1:0]             gate_mode,
    output logic                   dout,
    output logic                   dout_valid,
    output logic [2*NUM_ZONES-1:0] zone_phase
);

    localparam int LAST = NUM_ZONES - 1;

    logic                 step;
    logic [NUM_ZONES:0]   link_val;
    logic [NUM_ZONES:0]   link_pol;
    logic [1:0]           last_phase;

    qpipe_phase_gen #(
        .NUM_ZONES   (NUM_ZONES),
        .PHASE_CYCLES(PHASE_CYCLES)
    ) phase_gen_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .zone_phase(zone_phase),
        .step      (step)
    );

    // The input bit is always a polarized driver for zone 0.
    assign link_val[0] = din;
    assign link_pol[0] = 1'b1;

    generate
        for (genvar z = 0; z < NUM_ZONES; z++) begin : g_zone
            qpipe_zone #(
                .CELLS   (CELLS_PER_ZONE),
                .HAS_GATE(z == GATE_ZONE)
            ) zone_i (
                .clk      (clk),
                .rst_n    (rst_n),
                .phase    (zone_phase[2*z +: 2]),
                .step     (step),
                .up_val   (link_val[z]),
                .up_pol   (link_pol[z]),
                .side_in  (side_in),
                .gate_mode(gate_mode),
                .tail_val (link_val[z+1]),
                .tail_pol (link_pol[z+1])
            );
        end
    endgenerate

    assign last_phase = zone_phase[2*LAST +: 2];

    // Output: last cell value when polarized, qualified by hold.
    assign dout       = link_pol[NUM_ZONES] & link_val[NUM_ZONES];
    assign dout_valid = link_pol[NUM_ZONES] && (last_phase == PH_HOLD);

    // R7: valid can only start as the last zone moves from switch into hold
    a_r7_valid_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout_valid) |-> $past(last_phase) == PH_SWITCH);

endmodule

// File: tb/qpipe_chain_tb_top.sv
// Self-checking bench: a vector table for the gate modes, then directed reset,
// phase, null and stretched-step tests.
module qpipe_chain_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       din = 1'b0, side_in = 1'b0;
    logic [1:0] gate_mode = 2'd0;
    logic       dout, dout_valid;
    logic [7:0] zone_phase;

    logic       din_s = 1'b0;
    logic       dout_s, dout_valid_s;
    logic [7:0] zone_phase_s;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    qpipe_chain dut_i (
        .clk(clk), .rst_n(rst_n), .din(din), .side_in(side_in), .gate_mode(gate_mode),
        .dout(dout), .dout_valid(dout_valid), .zone_phase(zone_phase)
    );

    qpipe_chain #(.PHASE_CYCLES(3)) dut_slow_i (
        .clk(clk), .rst_n(rst_n), .din(din_s), .side_in(1'b0), .gate_mode(2'd0),
        .dout(dout_s), .dout_valid(dout_valid_s), .zone_phase(zone_phase_s)
    );

    // Each entry: {din, side_in, gate_mode[1:0], expected dout}
    localparam logic [4:0] VEC [10] = '{
        5'b1_0_00_1, 5'b0_1_00_0, 5'b1_1_01_1, 5'b1_0_01_0, 5'b0_1_01_0,
        5'b0_0_10_0, 5'b0_1_10_1, 5'b1_0_10_1, 5'b1_0_11_0, 5'b0_1_11_1
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 phases in reset", zone_phase, 8'hFF);
        check("R1 valid in reset", dout_valid, 0);
        check("R1 dout in reset", dout, 0);
        check("R1 slow phases in reset", zone_phase_s, 8'hFF);
        rst_n = 1'b1;
        #0;
        check("R1 phases in release cycle", zone_phase, 8'hFF);

        @(negedge clk);
        check("R2 R3 phases cycle 1", zone_phase, 8'h6C);
        @(negedge clk);
        check("R3 phases cycle 2", zone_phase, 8'hB1);
        check("R9 first hold is null", dout_valid, 0);
        @(negedge clk);
        check("R3 phases cycle 3", zone_phase, 8'hC6);
        @(negedge clk);
        check("R2 phases cycle 4", zone_phase, 8'h1B);

        // Vector table: one wave per period
        for (int i = 0; i < 10; i++) begin
            while (zone_phase[1:0] != 2'd0) @(negedge clk);
            din       = VEC[i][4];
            side_in   = VEC[i][3];
            gate_mode = VEC[i][2:1];
            repeat (4) @(negedge clk);
            check("R7 valid low in switch", dout_valid, 0);
            @(negedge clk);
            check("R7 valid in hold", dout_valid, 1);
            check("R6 R8 result", dout, VEC[i][0]);
            @(negedge clk);
            check("R5 null after hold valid", dout_valid, 0);
            check("R5 null after hold dout", dout, 0);
        end

        // R4: inputs changed after sampling do not reach this wave
        while (zone_phase[1:0] != 2'd0) @(negedge clk);
        din = 1'b1; side_in = 1'b0; gate_mode = 2'd0;
        @(negedge clk);
        din = 1'b0;
        @(negedge clk);
        gate_mode = 2'd3;
        repeat (3) @(negedge clk);
        check("R4 locked value valid", dout_valid, 1);
        check("R4 locked value", dout, 1);

        // Stretched steps on the slow instance
        while (zone_phase_s[1:0] != 2'd3) @(negedge clk);
        while (zone_phase_s[1:0] != 2'd0) @(negedge clk);
        din_s = 1'b1;
        @(negedge clk);
        check("R2 slow relax dwell 1", zone_phase_s[1:0], 0);
        @(negedge clk);
        check("R2 slow relax dwell 2", zone_phase_s[1:0], 0);
        @(negedge clk);
        check("R2 slow switch after dwell", zone_phase_s[1:0], 1);
        din_s = 1'b0;
        repeat (11) @(negedge clk);
        check("R7 slow valid before hold", dout_valid_s, 0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            din_s = ~din_s;
            check("R6 slow valid in hold", dout_valid_s, 1);
            check("R4 slow held value", dout_s, 1);
        end
        @(negedge clk);
        check("R5 slow null in release", dout_valid_s, 0);

        finish_run();
    end

endmodule